// File: doc/BRIEF.md
# Write-Through Data Cache with Freeze Control

This block is a small direct-mapped, write-through data cache that sits between a processor load/store port and a memory port. Each entry holds one 32-bit word with its tag and a valid flag. A read that hits is answered from the cache one cycle after the request and does not touch memory. A read that misses goes to memory, and the returned word may be installed in the indexed entry. Every write goes to memory. A write that hits also refreshes the cached word.

Three bits of a control word govern the cache. The enable bit (bit 8) turns the cache on. While it is clear, every access goes straight to memory and the storage is left alone, without being flushed, so entries that were valid can hit again once the cache is turned back on. The freeze bit (bit 9) stops misses from replacing entries, while write hits still refresh the data. The write-allocate bit (bit 13) decides whether a write miss installs the written word when the cache is not frozen.

Top module: `wt_dcache`

## Requirements
- R1: Reset clears the control word, so `ctrl_rdata` reads 0. It also invalidates all entries: after reset, a read of any address goes to memory even once the cache is enabled.
- R2: With the enable bit (bit 8) clear, every read and write makes exactly one memory access, and no entry is changed. A write made while the cache is off does not alter the word that a later hit returns.
- R3: With the cache enabled, a read whose index and tag match a valid entry raises `req_ready` in the cycle after the request, returns the cached word, and makes no memory access.
- R4: With the cache enabled and not frozen, a read miss fetches the word from memory, returns it, and installs it in the indexed entry, so that the next read of that address hits.
- R5: With the freeze bit (bit 9) set, a read miss or write miss leaves the indexed entry unchanged: the old address still hits and the missing address misses again.
- R6: With the cache frozen, a write that hits updates the cached word, so a following read hit returns the written data.
- R7: With the cache enabled and not frozen, a write miss installs the written word as a valid entry only if the write-allocate bit (bit 13) is set. With the bit clear, the indexed entry keeps its previous contents.
- R8: With the cache frozen, a write miss allocates nothing, even when the write-allocate bit is set.
- R9: Every processor write produces one memory write with the same address and data, in every control setting. The memory request holds its address until `mem_ready`.
- R10: Clearing and then setting the enable bit keeps the entries that were valid, and they hit again.
- R11: Hit detection compares the full tag. An address with the same index but a different tag misses and, when the cache is not frozen, replaces the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Load the control word |
| ctrl_wdata | input | 16 | New control word: bit 8 enable, bit 9 freeze, bit 13 write-allocate |
| ctrl_rdata | output | 16 | Current control word; only bits 8, 9 and 13 can be set |
| req_valid | input | 1 | Processor request; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word; bits 5:2 select the index, bits 31:6 form the tag |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | One-cycle pulse that completes the request |
| rsp_rdata | output | 32 | Read data, valid while `req_ready` is high for a read |
| mem_valid | output | 1 | Memory request, held until `mem_ready` |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |

## Verification
Some properties are checked on every cycle: a read hit with the cache on completes in one cycle with no memory request, every write becomes a memory write to the same address, nothing is written to storage while the cache is off, no tag is allocated while it is frozen, and memory requests stay stable until accepted. The replacement outcomes can only be seen through later accesses, so the bench shows them with sweeps over all sixteen indexes. These outcomes are: entries kept across disable, frozen misses that leave the old tag in place, write hits that refresh data under freeze, and allocation on write miss under each write-allocate setting. The bench uses a memory model whose read data is a fixed function of the address and ignores writes, so a word served by the cache is distinguishable from one fetched from memory.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RESP = 2'd2
  } dc_state_e;

  // control word bit positions
  localparam int unsigned EN_BIT  = 8;
  localparam int unsigned FRZ_BIT = 9;
  localparam int unsigned WA_BIT  = 13;

  // data array written when the access completes
  function automatic logic want_update(input logic en, input logic frz,
                                       input logic wa, input logic is_write,
                                       input logic hit);
    return en && (hit || (!frz && (!is_write || wa)));
  endfunction

  // tag and valid written (new entry installed)
  function automatic logic want_alloc(input logic en, input logic frz,
                                      input logic wa, input logic is_write,
                                      input logic hit);
    return en && !hit && !frz && (!is_write || wa);
  endfunction
endpackage

// File: rtl/dc_store.sv
module dc_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 26,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_data_en,
  input  logic              wr_tag_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    wire sel = (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
      end else if (wr_tag_en && sel) begin
        valid_q[e] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (wr_tag_en && sel) tag_q[e] <= wr_tag;
      if (wr_data_en && sel) data_q[e] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/dc_policy.sv
module dc_policy
  import dc_pkg::*;
(
  input  logic en,
  input  logic frz,
  input  logic wa,
  input  logic is_write,
  input  logic hit,
  output logic upd,
  output logic alloc
);
  always_comb begin
    upd   = want_update(en, frz, wa, is_write, hit);
    alloc = want_alloc(en, frz, wa, is_write, hit);
  end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import dc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned CTRL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [CTRL_W-1:0] CTRL_MASK =
    (CTRL_W'(1) << EN_BIT) | (CTRL_W'(1) << FRZ_BIT) | (CTRL_W'(1) << WA_BIT);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  dc_state_e         state_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              lat_write;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic [DATA_W-1:0] rsp_q;

  // named internal events
  wire st_idle  = (state_q == ST_IDLE);
  wire st_mem   = (state_q == ST_MEM);
  wire ctrl_en  = ctrl_q[EN_BIT];
  wire ctrl_frz = ctrl_q[FRZ_BIT];
  wire ctrl_wa  = ctrl_q[WA_BIT];
  wire mem_done = st_mem && mem_ready;

  logic [ADDR_W-1:0] look_addr;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              lookup_hit;
  logic              pol_upd, pol_alloc;
  logic              upd_en, upd_alloc;

  assign look_addr  = st_idle ? req_addr : lat_addr;
  assign lookup_hit = rd_valid && (rd_tag == tag_of(look_addr));
  assign upd_en     = mem_done && pol_upd;
  assign upd_alloc  = mem_done && pol_alloc;

  dc_store #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W)
  ) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (idx_of(look_addr)),
    .rd_valid   (rd_valid),
    .rd_tag     (rd_tag),
    .rd_data    (rd_data),
    .wr_data_en (upd_en),
    .wr_tag_en  (upd_alloc),
    .wr_idx     (idx_of(lat_addr)),
    .wr_tag     (tag_of(lat_addr)),
    .wr_data    (lat_write ? lat_wdata : mem_rdata)
  );

  dc_policy i_policy (
    .en       (ctrl_en),
    .frz      (ctrl_frz),
    .wa       (ctrl_wa),
    .is_write (lat_write),
    .hit      (lookup_hit),
    .upd      (pol_upd),
    .alloc    (pol_alloc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_wdata & CTRL_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      lat_write <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      rsp_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          lat_write <= req_write;
          lat_addr  <= req_addr;
          lat_wdata <= req_wdata;
          if (!req_write && ctrl_en && lookup_hit) begin
            rsp_q   <= rd_data;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ready) begin
          if (!lat_write) rsp_q <= mem_rdata;
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_rdata = ctrl_q;
  assign req_ready  = (state_q == ST_RESP);
  assign rsp_rdata  = rsp_q;
  assign mem_valid  = st_mem;
  assign mem_write  = lat_write;
  assign mem_addr   = lat_addr;
  assign mem_wdata  = lat_wdata;
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              st_idle,
  input logic              lookup_hit,
  input logic              ctrl_en,
  input logic              ctrl_frz,
  input logic              upd_en,
  input logic              upd_alloc
);
  p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && req_valid && !req_write && ctrl_en && lookup_hit)
      |=> (req_ready && !mem_valid));

  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  p_write_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && req_valid && req_write)
      |=> (mem_valid && mem_write && mem_addr == $past(req_addr)));

  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  p_off_no_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !(upd_en || upd_alloc));

  p_frozen_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_frz |-> !upd_alloc);
endmodule

bind wt_dcache dc_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_ready  (req_ready),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_write  (mem_write),
  .mem_addr   (mem_addr),
  .st_idle    (st_idle),
  .lookup_hit (lookup_hit),
  .ctrl_en    (ctrl_en),
  .ctrl_frz   (ctrl_frz),
  .upd_en     (upd_en),
  .upd_alloc  (upd_alloc)
);

// File: tb/test_wt_dcache.sv
module test_wt_dcache;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 2;
  localparam logic [15:0] C_EN  = 16'h0100;
  localparam logic [15:0] C_FRZ = 16'h0200;
  localparam logic [15:0] C_WA  = 16'h2000;
  localparam logic [25:0] T1 = 26'h0000123;
  localparam logic [25:0] T2 = 26'h2ABCDEF;
  localparam logic [25:0] T3 = 26'h1555555;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int mem_reads = 0;
  int mem_writes = 0;
  int lat_cnt = 0;
  logic [31:0] last_waddr = '0;
  logic [31:0] last_wdata = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wt_dcache i_wt_dcache (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A5A_3C3C;
  endfunction

  function automatic logic [31:0] mk_addr(input logic [25:0] t, input int i);
    return {t, 4'(i), 2'b00};
  endfunction

  // memory model: fixed data per address, writes only recorded
  always @(negedge clk) begin
    if (mem_valid && !mem_ready) begin
      if (lat_cnt == MEM_LAT) begin
        mem_ready = 1'b1;
        mem_rdata = mem_word(mem_addr);
        lat_cnt = 0;
        if (mem_write) begin
          mem_writes++;
          last_waddr = mem_addr;
          last_wdata = mem_wdata;
        end else begin
          mem_reads++;
        end
      end else begin
        lat_cnt++;
      end
    end else begin
      mem_ready = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [15:0] v);
    @(negedge clk);
    ctrl_wr = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int cyc, output int nmem);
    int m0;
    m0 = mem_reads + mem_writes;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr = a;
    req_wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!req_ready && cyc < 50);
    rd = rsp_rdata;
    req_valid = 1'b0;
    nmem = mem_reads + mem_writes - m0;
  endtask

  // read expected to hit with data exp
  task automatic read_hit(input logic [31:0] a, input logic [31:0] exp, input string req);
    logic [31:0] rd;
    int cyc, nm;
    access(1'b0, a, '0, rd, cyc, nm);
    check(cyc == 1 && nm == 0, req, 32'(cyc * 16 + nm), 32'h10);
    check(rd == exp, req, rd, exp);
  endtask

  // read expected to miss, returning memory data
  task automatic read_miss(input logic [31:0] a, input string req);
    logic [31:0] rd;
    int cyc, nm;
    access(1'b0, a, '0, rd, cyc, nm);
    check(cyc > 1 && nm == 1, req, 32'(nm), 32'd1);
    check(rd == mem_word(a), req, rd, mem_word(a));
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input string req);
    logic [31:0] rd;
    int cyc, nm;
    access(1'b1, a, d, rd, cyc, nm);
    check(nm == 1, {req, " R9 one mem write"}, 32'(nm), 32'd1);
    check(last_waddr == a && last_wdata == d, {req, " R9 addr/data"}, last_wdata, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1: reset state
    check(ctrl_rdata == 16'h0, "R1 ctrl cleared", 32'(ctrl_rdata), 32'h0);
    check(!req_ready && !mem_valid, "R1 idle outputs", 32'({req_ready, mem_valid}), 32'h0);

    set_ctrl(16'hFFFF);
    check(ctrl_rdata == (C_EN | C_FRZ | C_WA), "R1 ctrl mask", 32'(ctrl_rdata), 32'h2300);
    set_ctrl(C_EN);

    // R1/R4: all entries invalid after reset, misses fill
    for (int i = 0; i < 16; i++) read_miss(mk_addr(T1, i), "R1 miss after reset");
    for (int i = 0; i < 16; i++) read_hit(mk_addr(T1, i), mem_word(mk_addr(T1, i)), "R4/R3 hit after fill");

    // R2: disabled bypass, write while off leaves entries alone
    set_ctrl(16'h0000);
    for (int i = 0; i < 16; i++) read_miss(mk_addr(T1, i), "R2 off read to memory");
    do_write(mk_addr(T1, 4), 32'hDEAD_0004, "R2 off write");
    // R10: re-enable keeps entries
    set_ctrl(C_EN);
    for (int i = 0; i < 16; i++) read_hit(mk_addr(T1, i), mem_word(mk_addr(T1, i)), "R10/R2 kept across disable");

    // R11: same index, other tag
    read_miss(mk_addr(T2, 3), "R11 other tag misses");
    read_hit(mk_addr(T2, 3), mem_word(mk_addr(T2, 3)), "R11 replaced entry hits");
    read_miss(mk_addr(T1, 3), "R11 old tag evicted");
    read_hit(mk_addr(T1, 3), mem_word(mk_addr(T1, 3)), "R11 refill");

    // R5: frozen read misses do not replace
    set_ctrl(C_EN | C_FRZ);
    for (int i = 0; i < 16; i++) read_miss(mk_addr(T2, i), "R5 frozen miss");
    for (int i = 0; i < 16; i++) read_hit(mk_addr(T1, i), mem_word(mk_addr(T1, i)), "R5 old entry kept");
    read_miss(mk_addr(T2, 9), "R5 still missing");

    // R6: frozen write hit updates
    do_write(mk_addr(T1, 5), 32'hCAFE_0005, "R6 frozen write hit");
    read_hit(mk_addr(T1, 5), 32'hCAFE_0005, "R6 updated data");

    // R8: frozen write miss with allocate set
    set_ctrl(C_EN | C_FRZ | C_WA);
    do_write(mk_addr(T3, 6), 32'hBEEF_0006, "R8 frozen write miss");
    read_hit(mk_addr(T1, 6), mem_word(mk_addr(T1, 6)), "R8 entry kept");
    read_miss(mk_addr(T3, 6), "R8 no allocate");

    // R7: write miss without allocate
    set_ctrl(C_EN);
    do_write(mk_addr(T3, 7), 32'hBEEF_0007, "R7 write miss no alloc");
    read_hit(mk_addr(T1, 7), mem_word(mk_addr(T1, 7)), "R7 entry kept");
    read_miss(mk_addr(T3, 7), "R7 not allocated");

    // R7: write miss with allocate installs written word
    set_ctrl(C_EN | C_WA);
    for (int i = 8; i < 16; i++) do_write(mk_addr(T3, i), 32'hA110_0000 + 32'(i), "R7 alloc write");
    for (int i = 8; i < 16; i++) read_hit(mk_addr(T3, i), 32'hA110_0000 + 32'(i), "R7 allocated");

    // R1: reset invalidates again
    do_reset();
    check(ctrl_rdata == 16'h0, "R1 ctrl cleared again", 32'(ctrl_rdata), 32'h0);
    set_ctrl(C_EN);
    read_miss(mk_addr(T3, 8), "R1 invalid after reset");
    read_miss(mk_addr(T1, 0), "R1 invalid after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule